// File: doc/BRIEF.md
# UART Register Front End with Receive Buffer

This block is the software-facing half of a serial port. It decodes a simple word-addressed register bus, keeps the divisor, line, control, level-select and DMA settings, and holds incoming bytes in a receive buffer. The serial shifter behind it delivers each received byte with a one-cycle strobe. Each write to the data word becomes a one-cycle transmit strobe carrying the low byte. Baud generation, shifting, DMA and modem lines sit outside this block.

The receive buffer holds up to sixteen bytes when the buffer-enable bit of the line settings is set. When that bit is clear it holds a single byte. The flags word reports the buffer state. Two interrupt sources, receive and transmit, are latched as raw status, gated by a mask, and cleared by writing ones. Eight identification bytes occupy the top words of the 4 KiB register window.

Top module: `uart_reg_front`

## Requirements
- R1: After reset the flags word (word 6) reads 0x90, the control word (word 12) reads 0x300, the level-select word (word 13) reads 0x12, and raw status and `irq` are 0. In the flags word, bit 7 (transmit empty) always reads 1 and bit 5 (transmit full) always reads 0.
- R2: With line-settings bit 4 set, the buffer accepts up to 16 bytes. At 16 held bytes, flags bit 6 (receive full) is 1, `rx_ready` is 0, and a further strobe is dropped.
- R3: With line-settings bit 4 clear, the effective depth is 1. Flags bit 6 and `rx_ready`=0 appear after one byte, and a second strobe is dropped.
- R4: A read of word 0 returns the oldest held byte and removes it, so bytes leave in arrival order. When the last byte leaves, flags bit 4 (receive empty) becomes 1 and bit 6 becomes 0.
- R5: A read of word 0 while the buffer is empty returns the byte stored in the slot the read pointer addresses and moves no pointer. After reset every slot holds 0.
- R6: Raw status bit 4 (receive) sets when a byte arrives into an empty buffer. It clears when a read empties the buffer or when 1 is written to bit 4 of word 17.
- R7: A write to word 0 drives `tx_byte` with bit 7:0 of the write data and pulses `tx_valid` for exactly one cycle, starting the cycle after the write. It also sets raw status bit 5 (transmit).
- R8: Word 15 returns raw status, word 16 returns raw status AND the mask (word 14, 11 bits), and `irq` is 1 exactly when that masked value is nonzero.
- R9: A write to word 17 clears only the raw bits written as 1 and leaves the others set.
- R10: Byte addresses 0xFE0 to 0xFFC return, one per word, 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: The settings words keep only their implemented low bits: word 8 keeps 8, word 9 keeps 16, word 10 keeps 6, word 11 keeps 8, word 12 keeps 16, word 13 keeps 6, word 14 keeps 11 and word 18 keeps 3. Writes to words 6, 15 and 16 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 12 | Byte address within the register window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; a read of word 0 pops at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| rx_valid | input | 1 | Received byte strobe from the shifter |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Buffer can take a byte this cycle |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_byte | output | 8 | Byte to transmit |
| irq | output | 1 | Combined masked interrupt |

## Verification
A corrupt occupancy count shows up at the flags word and `rx_ready` on the very next cycle. If the buffer refuses bytes too early, later strobes are lost. If it accepts bytes past the effective depth, the oldest data is overwritten, and the reads of word 0 then return bytes out of order. A pointer fault is hidden until data is read back. The bench therefore drains full batches, and it checks the stale slot an empty read exposes, because that slot shows where the read pointer stopped. Interrupt state faults reach `irq` one edge after the event that caused them, so the bench reads raw status, masked status and `irq` together after each set or clear.

// File: rtl/uart_front_pkg.sv
// Package: shared register offsets, field widths, reset values and ID bytes
// for the UART register front end. Assumes a 32-bit word-addressed window.
package uart_front_pkg;
    // Word offsets (byte address divided by four)
    localparam int OFS_DATA  = 0;
    localparam int OFS_FLAG  = 6;
    localparam int OFS_LPDIV = 8;
    localparam int OFS_IBAUD = 9;
    localparam int OFS_FBAUD = 10;
    localparam int OFS_LINE  = 11;
    localparam int OFS_CTRL  = 12;
    localparam int OFS_LVL   = 13;
    localparam int OFS_MASK  = 14;
    localparam int OFS_RAW   = 15;
    localparam int OFS_MSTAT = 16;
    localparam int OFS_ICLR  = 17;
    localparam int OFS_DMA   = 18;

    // Implemented widths of the settings words
    localparam int LPDIV_W = 8;
    localparam int IBAUD_W = 16;
    localparam int FBAUD_W = 6;
    localparam int LINE_W  = 8;
    localparam int CTRL_W  = 16;
    localparam int LVL_W   = 6;
    localparam int MASK_W  = 11;
    localparam int DMA_W   = 3;

    localparam logic [CTRL_W-1:0] CTRL_RST = 16'h0300;
    localparam logic [LVL_W-1:0]  LVL_RST  = 6'h12;

    // Bit positions
    localparam int IRQ_RX_BIT   = 4;
    localparam int IRQ_TX_BIT   = 5;
    localparam int LINE_BUF_BIT = 4;

    // Identification byte for word index 0..7 of the top 32 bytes
    function automatic logic [7:0] ident_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h11;
            3'd1:    return 8'h10;
            3'd2:    return 8'h14;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/uart_cfg_reg.sv
// Module: a plain settings register with a write enable and a parameterised
// reset value. Assumes the caller has already trimmed the data to W bits.
module uart_cfg_reg #(
    parameter int          W   = 8,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Load on write, return to the reset value on reset
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST;
        else if (we) q <= d;
    end
endmodule

// File: rtl/uart_rx_fifo.sv
// Module: circular receive buffer with occupancy count. A pop while empty is
// ignored, and the head then shows the stale slot at the read pointer.
// Assumes the caller never pushes when the count equals DEPTH.
module uart_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     slot [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             pop_eff;

    assign pop_eff = pop && (count != '0);
    assign head    = slot[rd_ptr];

    // Storage: each slot loads when the write pointer selects it
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                                 slot[g] <= '0;
            else if (push && (wr_ptr == PTR_W'(g)))     slot[g] <= push_data;
        end
    end

    // Pointers wrap at DEPTH; the count follows the push and pop balance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_eff)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CNT_W'(push) - CNT_W'(pop_eff);
        end
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
// Module: raw interrupt status with set-over-clear priority, mask register
// and combined output. Assumes set and clear vectors are one-cycle events.
module uart_irq_ctrl #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    input  logic         mask_we,
    input  logic [W-1:0] mask_d,
    output logic [W-1:0] raw,
    output logic [W-1:0] mask,
    output logic         irq
);
    // Raw status: a set in the same cycle as a clear wins
    always_ff @(posedge clk) begin
        if (!rst_n) raw <= '0;
        else        raw <= (raw & ~clr_vec) | set_vec;
    end

    // Mask register, written whole
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= mask_d;
    end

    assign irq = |(raw & mask);
endmodule

// File: rtl/uart_reg_front.sv
// Module: top of the UART register front end. Decodes a single-cycle
// register bus, feeds the receive buffer, produces the transmit strobe and
// drives the interrupt sources. Assumes at most one of bus_wr and bus_rd
// per cycle. Read data is combinational.
module uart_reg_front
    import uart_front_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              irq
);
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int WORD_W  = ADDR_W - 2;
    localparam int RX_TRIG = 1;

    logic [WORD_W-1:0] word;
    logic              in_id;
    logic              wr_any;
    logic              we_lpdiv, we_ibaud, we_fbaud, we_line, we_ctrl;
    logic              we_lvl, we_mask, we_dma, we_data, we_iclr, rd_data;
    logic [LPDIV_W-1:0] lpdiv_q;
    logic [IBAUD_W-1:0] ibaud_q;
    logic [FBAUD_W-1:0] fbaud_q;
    logic [LINE_W-1:0]  line_q;
    logic [CTRL_W-1:0]  ctrl_q;
    logic [LVL_W-1:0]   lvl_q;
    logic [DMA_W-1:0]   dma_q;
    logic [MASK_W-1:0]  raw_stat, mask_q, set_vec, clr_vec;
    logic [CNT_W-1:0]   rx_count, depth_eff, cnt_after;
    logic [7:0]         rx_head, flag_word;
    logic               push, pop_eff, rx_full, rx_empty;

    assign word   = bus_addr[ADDR_W-1:2];
    assign in_id  = &bus_addr[ADDR_W-1:5];
    assign wr_any = bus_wr && !in_id;

    // Write-enable decode, one strobe per register word
    always_comb begin
        we_data  = wr_any && (word == WORD_W'(OFS_DATA));
        we_lpdiv = wr_any && (word == WORD_W'(OFS_LPDIV));
        we_ibaud = wr_any && (word == WORD_W'(OFS_IBAUD));
        we_fbaud = wr_any && (word == WORD_W'(OFS_FBAUD));
        we_line  = wr_any && (word == WORD_W'(OFS_LINE));
        we_ctrl  = wr_any && (word == WORD_W'(OFS_CTRL));
        we_lvl   = wr_any && (word == WORD_W'(OFS_LVL));
        we_mask  = wr_any && (word == WORD_W'(OFS_MASK));
        we_iclr  = wr_any && (word == WORD_W'(OFS_ICLR));
        we_dma   = wr_any && (word == WORD_W'(OFS_DMA));
        rd_data  = bus_rd && !in_id && (word == WORD_W'(OFS_DATA));
    end

    // Settings storage
    uart_cfg_reg #(.W(LPDIV_W), .RST('0)) u_lpdiv (.clk(clk), .rst_n(rst_n),
        .we(we_lpdiv), .d(bus_wdata[LPDIV_W-1:0]), .q(lpdiv_q));
    uart_cfg_reg #(.W(IBAUD_W), .RST('0)) u_ibaud (.clk(clk), .rst_n(rst_n),
        .we(we_ibaud), .d(bus_wdata[IBAUD_W-1:0]), .q(ibaud_q));
    uart_cfg_reg #(.W(FBAUD_W), .RST('0)) u_fbaud (.clk(clk), .rst_n(rst_n),
        .we(we_fbaud), .d(bus_wdata[FBAUD_W-1:0]), .q(fbaud_q));
    uart_cfg_reg #(.W(LINE_W), .RST('0)) u_line (.clk(clk), .rst_n(rst_n),
        .we(we_line), .d(bus_wdata[LINE_W-1:0]), .q(line_q));
    uart_cfg_reg #(.W(CTRL_W), .RST(CTRL_RST)) u_ctrl (.clk(clk), .rst_n(rst_n),
        .we(we_ctrl), .d(bus_wdata[CTRL_W-1:0]), .q(ctrl_q));
    uart_cfg_reg #(.W(LVL_W), .RST(LVL_RST)) u_lvl (.clk(clk), .rst_n(rst_n),
        .we(we_lvl), .d(bus_wdata[LVL_W-1:0]), .q(lvl_q));
    uart_cfg_reg #(.W(DMA_W), .RST('0)) u_dma (.clk(clk), .rst_n(rst_n),
        .we(we_dma), .d(bus_wdata[DMA_W-1:0]), .q(dma_q));

    // Effective depth follows the buffer-enable bit of the line settings
    assign depth_eff = line_q[LINE_BUF_BIT] ? CNT_W'(DEPTH) : CNT_W'(1);
    assign rx_ready  = rx_count < depth_eff;
    assign rx_full   = rx_count >= depth_eff;
    assign rx_empty  = (rx_count == '0);
    assign push      = rx_valid && rx_ready;
    assign pop_eff   = rd_data && !rx_empty;
    assign cnt_after = rx_count + CNT_W'(push) - CNT_W'(pop_eff);

    uart_rx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(rx_byte),
        .pop(rd_data), .head(rx_head), .count(rx_count));

    // Interrupt events: receive on reaching trigger, transmit on data write
    always_comb begin
        set_vec = '0;
        clr_vec = we_iclr ? bus_wdata[MASK_W-1:0] : '0;
        set_vec[IRQ_TX_BIT] = we_data;
        set_vec[IRQ_RX_BIT] = push && (cnt_after == CNT_W'(RX_TRIG));
        if (pop_eff && (cnt_after < CNT_W'(RX_TRIG)))
            clr_vec[IRQ_RX_BIT] = 1'b1;
    end

    uart_irq_ctrl #(.W(MASK_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
        .mask_we(we_mask), .mask_d(bus_wdata[MASK_W-1:0]),
        .raw(raw_stat), .mask(mask_q), .irq(irq));

    // Transmit strobe: one cycle after each data write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= we_data;
            if (we_data) tx_byte <= bus_wdata[7:0];
        end
    end

    // Flags: transmit side always empty and never full
    assign flag_word = {1'b1, rx_full, 1'b0, rx_empty, 4'b0000};

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (in_id) begin
            bus_rdata = DATA_W'(ident_byte(bus_addr[4:2]));
        end else begin
            case (word)
                WORD_W'(OFS_DATA):  bus_rdata = DATA_W'(rx_head);
                WORD_W'(OFS_FLAG):  bus_rdata = DATA_W'(flag_word);
                WORD_W'(OFS_LPDIV): bus_rdata = DATA_W'(lpdiv_q);
                WORD_W'(OFS_IBAUD): bus_rdata = DATA_W'(ibaud_q);
                WORD_W'(OFS_FBAUD): bus_rdata = DATA_W'(fbaud_q);
                WORD_W'(OFS_LINE):  bus_rdata = DATA_W'(line_q);
                WORD_W'(OFS_CTRL):  bus_rdata = DATA_W'(ctrl_q);
                WORD_W'(OFS_LVL):   bus_rdata = DATA_W'(lvl_q);
                WORD_W'(OFS_MASK):  bus_rdata = DATA_W'(mask_q);
                WORD_W'(OFS_RAW):   bus_rdata = DATA_W'(raw_stat);
                WORD_W'(OFS_MSTAT): bus_rdata = DATA_W'(raw_stat & mask_q);
                WORD_W'(OFS_DMA):   bus_rdata = DATA_W'(dma_q);
                default:            bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/uart_reg_front_chk.sv
// Module: property checker for the UART register front end, bound to the
// top. Assumes DEPTH matches the bound instance.
module uart_reg_front_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             rx_ready,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [11:0]      bus_addr,
    input logic [CNT_W-1:0] rx_count,
    input logic [7:0]       flag_word,
    input logic [10:0]      raw_stat,
    input logic [10:0]      mask_q,
    input logic             tx_valid,
    input logic             irq
);
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CNT_W'(DEPTH));

    p_refuse_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |-> flag_word[6]);

    p_drop_keeps_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready && !bus_rd) |=> (rx_count == $past(rx_count)));

    p_flag_consts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        flag_word[7] && !flag_word[5] && !(flag_word[6] && flag_word[4]));

    p_rx_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && rx_count == '0) |=> raw_stat[4]);

    p_tx_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[11:2] == 10'd0) |=> tx_valid);

    p_mask_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);
endmodule

bind uart_reg_front uart_reg_front_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .rx_count(rx_count), .flag_word(flag_word), .raw_stat(raw_stat),
    .mask_q(mask_q), .tx_valid(tx_valid), .irq(irq));

// File: tb/uart_reg_front_tb.sv
// Directed bench for the UART register front end: one task per scenario.
module uart_reg_front_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_byte;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    uart_reg_front u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq));

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int wordofs, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 12'(wordofs * 4); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 check(bus_rdata, exp, req);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_byte = b; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset;
        rd(12'h018, 32'h90, "R1 flags");
        rd(12'h030, 32'h300, "R1 control");
        rd(12'h034, 32'h12, "R1 level select");
        rd(12'h03C, 32'h0, "R1 raw");
        check(32'(irq), 32'h0, "R1 irq");
        check(32'(rx_ready), 32'h1, "R1 rx_ready");
    endtask

    task automatic t_regs;
        wr(8, 32'hFFFF_FFFF);  rd(12'h020, 32'hFF, "R11 low-power divisor");
        wr(9, 32'hFFFF_FFFF);  rd(12'h024, 32'hFFFF, "R11 integer baud");
        wr(10, 32'hFFFF_FFFF); rd(12'h028, 32'h3F, "R11 fractional baud");
        wr(12, 32'hFFFF_1234); rd(12'h030, 32'h1234, "R11 control");
        wr(13, 32'hFFFF_FFFF); rd(12'h034, 32'h3F, "R11 level select");
        wr(18, 32'hFFFF_FFFF); rd(12'h048, 32'h7, "R11 dma");
        wr(14, 32'hFFFF_FFFF); rd(12'h038, 32'h7FF, "R11 mask");
        wr(14, 32'h0);
        wr(11, 32'h1FF);       rd(12'h02C, 32'hFF, "R11 line");
        wr(11, 32'h0);
        wr(6, 32'h0);          rd(12'h018, 32'h90, "R11 flags read-only");
        wr(15, 32'hFFFF);      rd(12'h03C, 32'h0, "R11 raw read-only");
    endtask

    task automatic t_empty_read;
        rd(12'h000, 32'h0, "R5 empty read after reset");
        rd(12'h018, 32'h90, "R5 flags unchanged");
    endtask

    task automatic t_single_depth;
        wr(11, 32'h0);
        push(8'hA1);
        rd(12'h018, 32'hC0, "R3 full at one byte");
        check(32'(rx_ready), 32'h0, "R3 rx_ready low");
        push(8'hB2);
        rd(12'h000, 32'hA1, "R3 first byte kept, second dropped");
        rd(12'h018, 32'h90, "R4 empty after drain");
    endtask

    task automatic t_rx_irq;
        wr(14, 32'h10);
        push(8'h55);
        rd(12'h03C, 32'h10, "R6 raw rx set");
        rd(12'h040, 32'h10, "R8 masked rx");
        check(32'(irq), 32'h1, "R8 irq high");
        rd(12'h000, 32'h55, "R6 pop");
        rd(12'h03C, 32'h0, "R6 raw clears on drain");
        check(32'(irq), 32'h0, "R6 irq low");
        push(8'h66);
        wr(17, 32'h10);
        rd(12'h03C, 32'h0, "R6 cleared by write-one");
        rd(12'h018, 32'hC0, "R6 byte still held");
        rd(12'h000, 32'h66, "R6 pop held byte");
    endtask

    task automatic t_deep;
        wr(11, 32'h10);
        for (int i = 0; i < 16; i++) begin
            push(8'(8'h20 + i * 3));
            if (i == 14) rd(12'h018, 32'h80, "R2 neither full nor empty");
        end
        rd(12'h018, 32'hC0, "R2 full at sixteen");
        check(32'(rx_ready), 32'h0, "R2 rx_ready low");
        push(8'hEE);
        for (int i = 0; i < 16; i++)
            rd(12'h000, 32'(8'(8'h20 + i * 3)), "R4 order");
        rd(12'h018, 32'h90, "R4 empty after drain");
        // Three bytes went through before, so the pointer rests on the first byte of this batch
        rd(12'h000, 32'h20, "R5 stale slot at read pointer");
        rd(12'h018, 32'h90, "R5 flags unchanged");
        push(8'h77);
        rd(12'h000, 32'h77, "R5 pointers intact");
    endtask

    task automatic t_tx;
        wr(17, 32'h7FF);
        wr(14, 32'h20);
        @(negedge clk);
        bus_addr = 12'h000; bus_wdata = 32'h1C3; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check(32'(tx_valid), 32'h1, "R7 tx_valid pulse");
        check(32'(tx_byte), 32'hC3, "R7 tx_byte");
        @(negedge clk);
        check(32'(tx_valid), 32'h0, "R7 single cycle");
        rd(12'h03C, 32'h20, "R7 raw tx set");
        check(32'(irq), 32'h1, "R8 irq from tx");
    endtask

    task automatic t_iclr;
        push(8'h3C);
        rd(12'h03C, 32'h30, "R8 raw both");
        rd(12'h040, 32'h20, "R8 masked tx only");
        wr(17, 32'h20);
        rd(12'h03C, 32'h10, "R9 only tx cleared");
        check(32'(irq), 32'h0, "R8 irq masked off");
        wr(14, 32'h30);
        check(32'(irq), 32'h1, "R8 irq after unmask");
        wr(17, 32'h10);
        rd(12'h03C, 32'h0, "R9 rx cleared");
        rd(12'h000, 32'h3C, "R9 byte kept");
    endtask

    task automatic t_ident;
        logic [7:0] idv [8];
        idv = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 8; i++)
            rd(12'(12'hFE0 + i * 4), 32'(idv[i]), "R10 ident");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_regs;
        t_empty_read;
        t_single_depth;
        t_rx_irq;
        t_deep;
        t_tx;
        t_iclr;
        t_ident;
        if (!done) begin
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule